// File: doc/BRIEF.md
# Two-Wire Slave Register Bank

This block is a serial slave on a two-wire bus (one clock line, one open-drain data line). It gives a bus master read and write access to a bank of twenty byte-wide registers through an address pointer that advances by itself. The block oversamples both bus lines in its own system clock domain. It detects START and STOP conditions and checks the device address. It acknowledges bytes and shifts read data out most significant bit first. It only ever pulls the data line low.

A write transaction carries the device address with the direction bit clear. The first byte after it is the register pointer, and every later byte lands in the next register. A read transaction returns bytes from the current pointer onward until the master answers with a NACK. Three slots in the map (indexes 16, 17 and 18) hold no storage. A supply-fail input overrides the protocol engine. While it is high, the engine abandons the transfer, returns the pointer to index 0 and ignores the bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the data line is released (`sda_low_en` = 0), the pointer is 0 and every register reads 00h.
- R2: The address byte is the 7-bit device address 1101000b in bits 7..1 followed by the direction bit in bit 0 (0 = write, 1 = read). A matching address is acknowledged. Any other address is not acknowledged, and the bytes that follow are ignored until the next START.
- R3: In a write, the first byte after the address loads the pointer. Values 0 to 19 are taken as they are, and values of 20 or more load 0. Each following byte is stored at the pointer. The slave acknowledges the pointer byte and every data byte.
- R4: The pointer advances by one after each data byte, written or read, and steps from 19 back to 0.
- R5: In a read, the slave shifts out the register at the pointer, most significant bit first. The bit is valid while SCL is high.
- R6: Indexes 16 to 18 acknowledge writes but keep nothing, and they always read 00h.
- R7: When the master NACKs a read byte, the slave keeps the data line released for all further clocks until the next START.
- R8: A STOP returns the engine to idle. A repeated START restarts address reception and keeps the pointer value.
- R9: While `pwr_fail` is high, the transfer in progress ends, the pointer returns to 0, the data line is released and bus activity changes no register.
- R10: Apart from a power-fail abort, the slave changes its data-line drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | Supply-fail indication, synchronous to clk; high locks out the bus |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_low_en | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The main function is driven with plain multi-byte writes, and then with a write that sets the pointer followed by a repeated START into a read. The first pattern shows that data is stored. The second shows that the pointer survives the restart. A write that runs through 18, 19 and 0, read back starting from 16, tells reserved discarding apart from an off-by-one or a missing wrap. A foreign address followed by data, an out-of-range pointer byte, and a supply failure in the middle of a byte each separate "ignored" from "applied" by reading back a register whose value is already known to be non-zero.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } eng_st_e;

  // next pointer value, wrapping at the end of the bank
  function automatic int ptr_step(input int cur, input int nreg);
    return (cur >= nreg - 1) ? 0 : cur + 1;
  endfunction

  // pointer value loaded from a pointer byte
  function automatic int ptr_load(input int byte_v, input int nreg);
    return (byte_v < nreg) ? byte_v : 0;
  endfunction

  function automatic bit in_reserved(input int idx, input int lo, input int hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  assign q      = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter int NREG   = 20,
  parameter int RSV_LO = 16,
  parameter int RSV_HI = 18,
  parameter int PW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    if (in_reserved(i, RSV_LO, RSV_HI)) begin : g_rsv
      assign cells[i] = 8'h00;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                                cells[i] <= 8'h00;
        else if (wr_en && (wr_idx == PW'(i)))      cells[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == PW'(i)) rd_data = cells[i];
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int         NREG     = 20,
  parameter int         RSV_LO   = 16,
  parameter int         RSV_HI   = 18,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_low_en
);
  localparam int PW = $clog2(NREG);

  // synchronized lines and bus events
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_rb_sync #(.STAGES(SYNC_N)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_prev(scl_p));
  i2c_rb_sync #(.STAGES(SYNC_N)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_prev(sda_p));

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  // engine state
  eng_st_e       state_q;
  logic [3:0]    bcnt_q;
  logic [7:0]    shreg_q;
  logic [PW-1:0] ptr_q;
  logic          drv_q, rw_q, nack_q;

  logic          byte_done;
  logic          wr_en;
  logic [7:0]    rd_data;
  logic [PW-1:0] ptr_nxt;

  assign byte_done = scl_fall && (bcnt_q == 4'd8);
  assign ptr_nxt   = PW'(ptr_step(int'(ptr_q), NREG));
  assign wr_en     = !pwr_fail && byte_done && (state_q == ST_WDATA);

  i2c_rb_regs #(.NREG(NREG), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q),
    .wr_data(shreg_q), .rd_idx(ptr_q), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      drv_q   <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else if (pwr_fail) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      ptr_q   <= '0;
      drv_q   <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      bcnt_q  <= '0;
      drv_q   <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      drv_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            bcnt_q  <= bcnt_q + 4'd1;
          end else if (byte_done) begin
            bcnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                rw_q    <= shreg_q[0];
                drv_q   <= 1'b1;
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_q   <= PW'(ptr_load(int'(shreg_q), NREG));
              drv_q   <= 1'b1;
              state_q <= ST_WACK;
            end else begin
              ptr_q   <= ptr_nxt;
              drv_q   <= 1'b1;
              state_q <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bcnt_q <= '0;
            if (rw_q) begin
              shreg_q <= rd_data;
              drv_q   <= ~rd_data[7];
              state_q <= ST_RDATA;
            end else begin
              drv_q   <= 1'b0;
              state_q <= ST_PTR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            drv_q   <= 1'b0;
            bcnt_q  <= '0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bcnt_q <= bcnt_q + 4'd1;
          end else if (byte_done) begin
            drv_q   <= 1'b0;
            bcnt_q  <= '0;
            state_q <= ST_RACK;
          end else if (scl_fall) begin
            drv_q   <= ~shreg_q[6];
            shreg_q <= {shreg_q[6:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ptr_q  <= ptr_nxt;
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_q <= ST_HOLD;
            end else begin
              shreg_q <= rd_data;
              drv_q   <= ~rd_data[7];
              state_q <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_low_en = drv_q;
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk #(
  parameter int NREG = 20,
  parameter int PW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          scl_s,
  input logic          sda_low_en,
  input logic          start_ev,
  input logic          wr_en,
  input logic [PW-1:0] ptr
);
  // R9
  pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ptr == '0) && !sda_low_en);

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NREG);

  // R4
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> int'(ptr) == ((int'($past(ptr)) + 1) % NREG));

  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_low_en) && !$past(pwr_fail)) |-> !scl_s);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_low_en);
endmodule

bind i2c_regbank_slave i2c_rb_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_s(scl_s),
  .sda_low_en(sda_low_en), .start_ev(start_ev), .wr_en(wr_en), .ptr(ptr_q));

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;
  localparam int Q = 10;
  localparam int NR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_low_en;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m [NR];
  int mptr = 0;
  logic [7:0] wdat [$];

  always #2 clk = ~clk;

  assign sda_line = msda & ~sda_low_en;

  i2c_regbank_slave u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .scl_i(scl), .sda_i(sda_line), .sda_low_en(sda_low_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor of drive behaviour (R9, R10)
  logic prev_drv = 1'b0;
  logic prev_pf  = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pf) chk(sda_low_en == 1'b0, "R9 drive released under power fail", sda_low_en, 0);
      if ((sda_low_en != prev_drv) && !prev_pf)
        chk(scl == 1'b0, "R10 drive change while SCL high", scl, 0);
    end
    prev_drv = sda_low_en;
    prev_pf  = pwr_fail;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    msda = 1'b1; wq(); scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    msda = ack ? 1'b0 : 1'b1;
    wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    msda = 1'b1;
  endtask

  task automatic model_wr(input logic [7:0] v);
    if (mptr < 16 || mptr > 18) m[mptr] = v;
    mptr = (mptr + 1) % NR;
  endtask

  // write transaction: pointer byte then the bytes in wdat
  task automatic wr_regs(input int p);
    bit a;
    bus_start();
    send_byte(8'hD0, a); chk(a, "R2 write address ack", a, 1);
    send_byte(8'(p), a); chk(a, "R3 pointer byte ack", a, 1);
    mptr = (p < NR) ? p : 0;
    foreach (wdat[i]) begin
      send_byte(wdat[i], a);
      if (mptr >= 16 && mptr <= 18) chk(a, "R6 reserved write ack", a, 1);
      else                          chk(a, "R3 data byte ack", a, 1);
      model_wr(wdat[i]);
    end
    bus_stop();
  endtask

  // read transaction of n bytes from the current pointer
  task automatic rd_regs(input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD1, a); chk(a, "R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == m[mptr], req, b, m[mptr]);
      mptr = (mptr + 1) % NR;
    end
    bus_stop();
  endtask

  initial begin : main
    bit a;
    bit ok;
    logic [7:0] b;
    for (int i = 0; i < NR; i++) m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(sda_low_en == 1'b0, "R1 released after reset", sda_low_en, 0);
    rd_regs(2, "R1 reset contents from pointer 0");

    // R3 basic write
    wdat = {8'h11, 8'h22, 8'h33};
    wr_regs(5);

    // R8 repeated start keeps the pointer; R5 read data
    bus_start();
    send_byte(8'hD0, a); chk(a, "R2 address ack", a, 1);
    send_byte(8'h05, a); chk(a, "R3 pointer ack", a, 1);
    mptr = 5;
    bus_start();
    send_byte(8'hD1, a); chk(a, "R8 address ack after repeated start", a, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, b);
      chk(b == m[mptr], "R8 R5 read after repeated start", b, m[mptr]);
      mptr = (mptr + 1) % NR;
    end
    // R7 released after NACK
    ok = 1;
    msda = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wq(); scl = 1'b1; wq();
      if (sda_line != 1'b1) ok = 0;
      wq(); scl = 1'b0; wq();
    end
    chk(ok, "R7 line released after NACK", ok, 1);
    bus_stop();

    // R2 foreign address ignored
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h05, a); chk(!a, "R2 byte after foreign address not acked", a, 0);
    send_byte(8'h99, a);
    bus_stop();
    wdat = {};
    wr_regs(5);
    rd_regs(1, "R2 register untouched by foreign transfer");

    // R4 wrap and R6 reserved
    wdat = {8'hAA, 8'hBB, 8'hCC};
    wr_regs(18);
    wdat = {};
    wr_regs(16);
    rd_regs(5, "R4 R6 wrap and reserved read");

    // R3 out-of-range pointer loads 0
    wr_regs(25);
    rd_regs(1, "R3 pointer 25 loads 0");

    // R9 power fail mid-byte
    bus_start();
    send_byte(8'hD0, a); chk(a, "R2 address ack", a, 1);
    send_byte(8'h03, a); chk(a, "R3 pointer ack", a, 1);
    mptr = 3;
    send_byte(8'h44, a); chk(a, "R3 data ack", a, 1);
    model_wr(8'h44);
    for (int i = 7; i >= 5; i--) begin
      msda = 1'(8'h55 >> i); wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    pwr_fail = 1'b1;
    for (int i = 4; i >= 0; i--) begin
      msda = 1'(8'h55 >> i); wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    msda = 1'b1; wq(); scl = 1'b1; wq();
    chk(sda_line == 1'b1, "R9 no ack under power fail", sda_line, 1);
    wq(); scl = 1'b0; wq();
    send_byte(8'h66, a); chk(!a, "R9 bus ignored under power fail", a, 0);
    bus_stop();
    pwr_fail = 1'b0;
    mptr = 0;
    repeat (4) @(negedge clk);
    rd_regs(1, "R9 pointer reset to 0");
    wdat = {};
    wr_regs(3);
    rd_regs(2, "R9 no write under power fail");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule